// File: doc/BRIEF.md
# Serial Line Automatic Bit-Rate Aligner

This block listens on an idle asynchronous serial line (8 data bits, 1 stop bit, no parity) and works out the bit rate of the far end. It does not need a programmed rate. The host opens by sending a calibration byte of 0x00. With that byte, the start bit and all eight data bits form one unbroken low stretch that lasts nine bit times. The block counts system clocks across that stretch and divides the count by nine, rounding to nearest, to get a clocks-per-bit divisor.

The line must then stay high for one full bit time. After that, the block sends a 0x00 byte at the learned rate to tell the host that alignment is complete. It then waits for the host to answer with 0x55 at the same rate. A correct answer sets the locked flag.

A run that is too long, a divisor that is too small, a short stop bit, a wrong reply or a missing reply all set a sticky error flag. The only way out is a reset, which re-arms a fresh measurement.

Top module: `baud_aligner`

## Requirements
- R1: After reset, `tx` is high, `divisor` is 0, and `align_done`, `link_locked` and `link_error` are 0.
- R2: A measurement starts only on a falling edge of `rx` that follows at least IDLE_CLKS consecutive high clocks since reset. An earlier low run is ignored: it leaves `divisor` at 0 and raises no flag.
- R3: For a low run of L clocks, `divisor` becomes floor((L + 4) / 9). It holds that value until reset.
- R4: A low run longer than 2^CNT_W − 1 clocks sets `link_error`, leaves `divisor` at 0, and sends nothing.
- R5: A computed divisor below MIN_DIV sets `link_error` and leaves `divisor` at 0.
- R6: If `rx` falls within one learned bit time after the run ends, `link_error` is set and `tx` stays high.
- R7: Once the line has stayed high for one learned bit time, `tx` sends the byte 0x00. The frame is one low start bit, eight low data bits and one high stop bit, each `divisor` clocks long. `align_done` rises when the stop bit ends.
- R8: A reply frame received at the learned rate, with data 0x55 (sent LSB first) and a high stop bit, sets `link_locked`. Each bit is sampled half a bit time after the start edge and then once per bit time.
- R9: A reply whose data is not 0x55, or whose stop bit is low, sets `link_error` and leaves `link_locked` at 0.
- R10: If no start bit arrives within TMO_BITS learned bit times after `align_done` rises, `link_error` is set.
- R11: `link_locked` and `link_error` stay set until reset, whatever arrives on `rx`. A reset re-arms a new measurement.
- R12: `link_locked` and `link_error` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; re-arms measurement |
| rx | input | 1 | Asynchronous serial input from host |
| tx | output | 1 | Serial output to host, idle high |
| divisor | output | CNT_W-3 | Learned clocks per bit, 0 until learned |
| align_done | output | 1 | Acknowledge byte fully sent |
| link_locked | output | 1 | Confirm byte 0x55 received correctly |
| link_error | output | 1 | Sticky failure flag |

## Verification
The input passes through two synchroniser flops, and the run end is registered twice more. As a result, `divisor` and the measurement error flags settle four clocks after `rx` rises, and the bench reads them twelve clocks after the rise. The acknowledge frame starts about one bit time plus a few clocks after the rise. The bench therefore waits for the falling edge of `tx` and then samples each bit at its middle, which makes the check independent of that fixed latency. The outcome of the reply is due a few clocks after the middle of its stop bit, so the bench reads the flags after the whole frame has been sent. The timeout is checked once two bit times before it is due and once three bit times after.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [2:0] {
        S_MEAS,
        S_STOP,
        S_ACK,
        S_LISTEN,
        S_LOCK,
        S_FAIL
    } seq_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       stop_ok;
    } rx_frame_t;

    localparam logic [7:0] ACK_BYTE     = 8'h00;
    localparam logic [7:0] CONFIRM_BYTE = 8'h55;
    localparam int         LOW_BITS     = 9;

    // Rounded per-bit time from the length of the all-low run.
    function automatic logic [31:0] bit_time_from_run(input logic [31:0] run);
        return (run + 32'(LOW_BITS / 2)) / 32'(LOW_BITS);
    endfunction

endpackage

// File: rtl/baud_lowmeter.sv
module baud_lowmeter #(
    parameter int CNT_W     = 17,
    parameter int IDLE_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    output logic             run_done,
    output logic [CNT_W-1:0] run_len,
    output logic             run_ovf
);
    localparam int               IDLE_W  = $clog2(IDLE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [IDLE_W-1:0] idle_cnt;
    logic [CNT_W-1:0]  cnt;
    logic              prev;
    logic              busy;

    always_ff @(posedge clk) begin
        run_done <= 1'b0;
        if (rst || !en) begin
            idle_cnt <= '0;
            cnt      <= '0;
            prev     <= 1'b0;
            busy     <= 1'b0;
            run_len  <= '0;
            run_ovf  <= 1'b0;
        end else begin
            prev <= line;
            if (!busy) begin
                if (line) begin
                    if (idle_cnt != IDLE_W'(IDLE_CLKS)) idle_cnt <= idle_cnt + 1'b1;
                end else begin
                    idle_cnt <= '0;
                end
                if (!line && prev && idle_cnt == IDLE_W'(IDLE_CLKS)) begin
                    busy <= 1'b1;
                    cnt  <= CNT_W'(1);
                end
            end else if (!line) begin
                if (cnt == CNT_MAX) begin
                    run_ovf  <= 1'b1;
                    run_done <= 1'b1;
                    busy     <= 1'b0;
                    idle_cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                run_len  <= cnt;
                run_done <= 1'b1;
                busy     <= 1'b0;
                idle_cnt <= '0;
            end
        end
    end

    // R3: a completed run always reports a non-empty length
    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (run_done && !run_ovf) |-> (run_len != '0));

endmodule

// File: rtl/baud_tx.sv
module baud_tx #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       data,
    output logic             tx,
    output logic             fin
);
    logic [9:0]       sh;
    logic [DIV_W-1:0] ccnt;
    logic [3:0]       bidx;
    logic             busy;

    always_ff @(posedge clk) begin
        fin <= 1'b0;
        if (rst) begin
            sh   <= '1;
            ccnt <= '0;
            bidx <= '0;
            busy <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                sh   <= {1'b1, data, 1'b0};
                ccnt <= '0;
                bidx <= '0;
                busy <= 1'b1;
            end
        end else if (ccnt == div - DIV_W'(1)) begin
            ccnt <= '0;
            sh   <= {1'b1, sh[9:1]};
            if (bidx == 4'd9) begin
                busy <= 1'b0;
                fin  <= 1'b1;
            end else begin
                bidx <= bidx + 1'b1;
            end
        end else begin
            ccnt <= ccnt + 1'b1;
        end
    end

    assign tx = sh[0];

    // R7: the line idles high between frames
    p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

endmodule

// File: rtl/baud_rx.sv
module baud_rx
    import baud_pkg::*;
#(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    input  logic [DIV_W-1:0] div,
    output logic             got,
    output rx_frame_t        frame,
    output logic             active
);
    logic             prev;
    logic [DIV_W-1:0] ccnt;
    logic [3:0]       bidx;
    logic [7:0]       sh;
    logic [DIV_W-1:0] tgt;

    assign tgt = (bidx == 4'd0) ? (div >> 1) : div;

    always_ff @(posedge clk) begin
        got <= 1'b0;
        if (rst || !en) begin
            prev   <= 1'b0;
            active <= 1'b0;
            ccnt   <= '0;
            bidx   <= '0;
            sh     <= '0;
            frame  <= '0;
        end else begin
            prev <= line;
            if (!active) begin
                if (prev && !line) begin
                    active <= 1'b1;
                    ccnt   <= DIV_W'(1);
                    bidx   <= '0;
                end
            end else if (ccnt == tgt) begin
                ccnt <= DIV_W'(1);
                if (bidx == 4'd0) begin
                    if (line) active <= 1'b0;
                    else      bidx   <= 4'd1;
                end else if (bidx <= 4'd8) begin
                    sh   <= {line, sh[7:1]};
                    bidx <= bidx + 1'b1;
                end else begin
                    frame  <= '{data: sh, stop_ok: line};
                    got    <= 1'b1;
                    active <= 1'b0;
                end
            end else begin
                ccnt <= ccnt + 1'b1;
            end
        end
    end

    // R8: one result pulse per received frame
    p_got_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        got |=> !got);

endmodule

// File: rtl/baud_aligner.sv
module baud_aligner
    import baud_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int MIN_DIV   = 16,
    parameter int IDLE_CLKS = 64,
    parameter int TMO_BITS  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    output logic             tx,
    output logic [CNT_W-4:0] divisor,
    output logic             align_done,
    output logic             link_locked,
    output logic             link_error
);
    localparam int DIV_W = CNT_W - 3;
    localparam int TB_W  = $clog2(TMO_BITS + 1);

    seq_state_e       st;
    logic             rx_m, rx_s;
    logic             run_done, run_ovf;
    logic [CNT_W-1:0] run_len;
    logic [DIV_W-1:0] div_calc;
    logic [DIV_W-1:0] wcnt;
    logic [TB_W-1:0]  tbits;
    logic             tx_go, tx_fin;
    logic             rx_got, rx_active;
    rx_frame_t        rx_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rx;
            rx_s <= rx_m;
        end
    end

    baud_lowmeter #(.CNT_W(CNT_W), .IDLE_CLKS(IDLE_CLKS)) u_meter (
        .clk(clk), .rst(rst), .en(st == S_MEAS), .line(rx_s),
        .run_done(run_done), .run_len(run_len), .run_ovf(run_ovf)
    );

    assign div_calc = DIV_W'(bit_time_from_run(32'(run_len)));

    baud_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst(rst), .start(tx_go), .div(divisor),
        .data(ACK_BYTE), .tx(tx), .fin(tx_fin)
    );

    baud_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .en(st == S_LISTEN), .line(rx_s), .div(divisor),
        .got(rx_got), .frame(rx_frame), .active(rx_active)
    );

    always_ff @(posedge clk) begin
        tx_go <= 1'b0;
        if (rst) begin
            st          <= S_MEAS;
            divisor     <= '0;
            align_done  <= 1'b0;
            link_locked <= 1'b0;
            link_error  <= 1'b0;
            wcnt        <= '0;
            tbits       <= '0;
        end else begin
            case (st)
                S_MEAS: if (run_done) begin
                    if (run_ovf || div_calc < DIV_W'(MIN_DIV)) begin
                        link_error <= 1'b1;
                        st         <= S_FAIL;
                    end else begin
                        divisor <= div_calc;
                        wcnt    <= '0;
                        st      <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (!rx_s) begin
                        link_error <= 1'b1;
                        st         <= S_FAIL;
                    end else if (wcnt == divisor - DIV_W'(1)) begin
                        tx_go <= 1'b1;
                        st    <= S_ACK;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                S_ACK: if (tx_fin) begin
                    align_done <= 1'b1;
                    wcnt       <= '0;
                    tbits      <= '0;
                    st         <= S_LISTEN;
                end
                S_LISTEN: begin
                    if (rx_got) begin
                        if (rx_frame.data == CONFIRM_BYTE && rx_frame.stop_ok) begin
                            link_locked <= 1'b1;
                            st          <= S_LOCK;
                        end else begin
                            link_error <= 1'b1;
                            st         <= S_FAIL;
                        end
                    end else if (!rx_active) begin
                        if (tbits == TB_W'(TMO_BITS)) begin
                            link_error <= 1'b1;
                            st         <= S_FAIL;
                        end else if (wcnt == divisor - DIV_W'(1)) begin
                            wcnt  <= '0;
                            tbits <= tbits + 1'b1;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(link_locked && link_error));
    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        link_locked |=> link_locked);
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        link_error |=> link_error);
    p_div_floor_r5: assert property (@(posedge clk) disable iff (rst)
        align_done |-> (divisor >= DIV_W'(MIN_DIV)));
    p_div_hold_r3: assert property (@(posedge clk) disable iff (rst)
        align_done |=> $stable(divisor));
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (link_error && !align_done) |-> tx);

endmodule

// File: tb/baud_aligner_test.sv
module baud_aligner_test;
    localparam int CNT_W = 10;
    localparam int MIN_D = 16;
    localparam int IDLE  = 8;
    localparam int TMO   = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx  = 1'b1;
    logic             tx;
    logic [CNT_W-4:0] divisor;
    logic             align_done, link_locked, link_error;
    int               checks = 0;
    int               fails  = 0;

    always #5 clk = ~clk;

    baud_aligner #(.CNT_W(CNT_W), .MIN_DIV(MIN_D), .IDLE_CLKS(IDLE), .TMO_BITS(TMO)) uut (
        .clk(clk), .rst(rst), .rx(rx), .tx(tx), .divisor(divisor),
        .align_done(align_done), .link_locked(link_locked), .link_error(link_error)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx  = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cal(input int len);
        hold(1'b1, 20);
        hold(1'b0, len);
        rx = 1'b1;
    endtask

    task automatic send_byte(input int d, input logic [7:0] b, input logic stp);
        hold(1'b0, d);
        for (int i = 0; i < 8; i++) hold(b[i], d);
        hold(stp, d);
        rx = 1'b1;
    endtask

    // R7: locate the start edge of the acknowledge frame, then sample each bit mid-way
    task automatic check_ack(input int d);
        int waited = 0;
        while (tx !== 1'b0 && waited < 4 * d + 60) begin
            @(negedge clk);
            waited++;
        end
        chk("R7 ack start seen", int'(tx === 1'b0), 1);
        repeat (d / 2) @(negedge clk);
        for (int b = 0; b < 10; b++) begin
            chk("R7 ack bit", int'(tx), (b == 9) ? 1 : 0);
            repeat (d) @(negedge clk);
        end
        chk("R7 align_done", int'(align_done), 1);
    endtask

    task automatic run_link(input int d, input logic [7:0] b, input logic stp, input logic good);
        do_reset();
        send_cal(9 * d);
        check_ack(d);
        chk("R3 divisor", int'(divisor), d);
        send_byte(d, b, stp);
        repeat (4) @(negedge clk);
        chk(good ? "R8 locked" : "R9 locked", int'(link_locked), int'(good));
        chk(good ? "R8 error" : "R9 error", int'(link_error), int'(!good));
        chk("R12 exclusive", int'(link_locked && link_error), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int low_seen;
        do_reset();
        @(negedge clk);
        chk("R1 tx", int'(tx), 1);
        chk("R1 divisor", int'(divisor), 0);
        chk("R1 done", int'(align_done), 0);
        chk("R1 locked", int'(link_locked), 0);
        chk("R1 error", int'(link_error), 0);

        // R2: a run before enough idle is ignored
        do_reset();
        hold(1'b1, 3);
        hold(1'b0, 200);
        hold(1'b1, 12);
        chk("R2 ignored divisor", int'(divisor), 0);
        chk("R2 ignored error", int'(link_error), 0);
        chk("R2 ignored done", int'(align_done), 0);
        hold(1'b0, 9 * 20);
        hold(1'b1, 12);
        chk("R2 armed divisor", int'(divisor), 20);

        // R3: sweep of run lengths, rounded divide by nine
        for (int len = 140; len <= 330; len++) begin
            do_reset();
            send_cal(len);
            repeat (12) @(negedge clk);
            chk("R3 sweep divisor", int'(divisor), (len + 4) / 9);
            chk("R3 sweep error", int'(link_error), 0);
        end
        do_reset();
        send_cal(1023);
        repeat (12) @(negedge clk);
        chk("R3 longest run", int'(divisor), (1023 + 4) / 9);

        // R4: overflow of the run counter
        do_reset();
        send_cal(1100);
        repeat (12) @(negedge clk);
        chk("R4 error", int'(link_error), 1);
        chk("R4 divisor", int'(divisor), 0);
        low_seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tx == 1'b0) low_seen++;
        end
        chk("R4 no ack", low_seen, 0);

        // R5: divisor below the minimum
        for (int len = 135; len <= 139; len++) begin
            do_reset();
            send_cal(len);
            repeat (12) @(negedge clk);
            chk("R5 error", int'(link_error), 1);
            chk("R5 divisor", int'(divisor), 0);
        end

        // R6: stop bit cut short
        do_reset();
        hold(1'b1, 20);
        hold(1'b0, 9 * 24);
        hold(1'b1, 8);
        hold(1'b0, 40);
        rx = 1'b1;
        low_seen = 0;
        for (int i = 0; i < 30 * 24; i++) begin
            @(negedge clk);
            if (tx == 1'b0) low_seen++;
        end
        chk("R6 tx quiet", low_seen, 0);
        chk("R6 error", int'(link_error), 1);
        chk("R6 done", int'(align_done), 0);

        // R7 and R8: good handshakes at several rates
        run_link(16, 8'h55, 1'b1, 1'b1);
        run_link(24, 8'h55, 1'b1, 1'b1);
        run_link(37, 8'h55, 1'b1, 1'b1);
        run_link(50, 8'h55, 1'b1, 1'b1);
        // R11: a later frame leaves the lock in place
        send_byte(50, 8'h00, 1'b1);
        repeat (10) @(negedge clk);
        chk("R11 lock sticky", int'(link_locked), 1);
        chk("R11 no error after lock", int'(link_error), 0);

        // R9: wrong reply bytes and a low stop bit
        for (int k = 0; k < 8; k++) run_link(16, 8'h55 ^ (8'h01 << k), 1'b1, 1'b0);
        run_link(16, 8'h00, 1'b1, 1'b0);
        run_link(16, 8'hFF, 1'b1, 1'b0);
        run_link(20, 8'h55, 1'b0, 1'b0);
        // R11: a correct reply after failure does not clear the error
        send_byte(20, 8'h55, 1'b1);
        repeat (10) @(negedge clk);
        chk("R11 error sticky", int'(link_error), 1);
        chk("R11 no lock after error", int'(link_locked), 0);

        // R10: no reply
        do_reset();
        send_cal(9 * 16);
        check_ack(16);
        repeat ((TMO - 3) * 16) @(negedge clk);
        chk("R10 before timeout", int'(link_error), 0);
        repeat (5 * 16) @(negedge clk);
        chk("R10 after timeout", int'(link_error), 1);
        chk("R10 locked", int'(link_locked), 0);

        // R11: reset re-arms a fresh measurement
        run_link(30, 8'h55, 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule